// File: doc/BRIEF.md
# Single-Step Sign-Aware Word Shifter

This block moves a data word by exactly one bit position, either toward the most significant end or toward the least significant end. It has two modes. The plain mode moves every bit and fills the vacated end with zero. The signed mode treats the top bit as a sign that never moves. In that mode a left move shifts only the magnitude bits below the sign, and a right move copies the sign into the position just under it. Either way the value's magnitude doubles on a left move and halves on a right move.

The result word and the single bit pushed off the end are captured in output registers on the clock edge that follows the inputs. A synchronous active-high reset clears both registers. The word width is a parameter with a default of 8 bits and a minimum of 3.

Top module: `sps_shifter`

## Requirements
- R1: While `rst` is high at a rising clock edge, both `res_word` and `res_spill` become 0 on that edge, whatever the other inputs are.
- R2: The outputs change only on a rising clock edge. They reflect the inputs sampled on the most recent edge, so the latency is one cycle.
- R3: When `in_dir`=0 (left) and `in_mode`=0 (plain), `res_word` = {in_word[W-2:0], 0} and `res_spill` = in_word[W-1].
- R4: When `in_dir`=1 (right) and `in_mode`=0 (plain), `res_word` = {0, in_word[W-1:1]} and `res_spill` = in_word[0].
- R5: When `in_dir`=0 (left) and `in_mode`=1 (signed), `res_word` = {in_word[W-1], in_word[W-3:0], 0} and `res_spill` = in_word[W-2].
- R6: When `in_dir`=1 (right) and `in_mode`=1 (signed), `res_word` = {in_word[W-1], in_word[W-1], in_word[W-2:1]} and `res_spill` = in_word[0].
- R7: In signed mode (`in_mode`=1), bit W-1 of `res_word` always equals bit W-1 of the sampled `in_word`, for both directions.
- R8: Any left move leaves bit 0 of `res_word` at 0, and a plain right move leaves bit W-1 of `res_word` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_word | input | W | Word to be moved |
| in_dir | input | 1 | Direction: 0 = toward MSB, 1 = toward LSB |
| in_mode | input | 1 | Mode: 0 = plain, 1 = signed (top bit fixed) |
| res_word | output | W | Registered moved word |
| res_spill | output | 1 | Registered bit pushed off the end |

## Verification
On every cycle the bound checker compares the registered outputs with the inputs sampled one edge earlier, in each of the four direction and mode pairings. It also checks the fixed sign in signed mode, the zero fill at the vacated ends, and the cleared state after reset. The bench shows what the checker cannot. It walks every 8-bit word through all four pairings against its own arithmetic model, uses hand-picked words such as a lone sign bit and all ones, confirms that the outputs hold between edges, and asserts reset while nonzero data is present.

// File: rtl/sps_pkg.sv
package sps_pkg;

  typedef enum logic {
    DIR_LEFT  = 1'b0,
    DIR_RIGHT = 1'b1
  } sps_dir_e;

  typedef enum logic {
    MODE_PLAIN  = 1'b0,
    MODE_SIGNED = 1'b1
  } sps_mode_e;

endpackage

// File: rtl/sps_core.sv
module sps_core
  import sps_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] src,
  input  sps_dir_e     dir,
  input  sps_mode_e    mode,
  output logic [W-1:0] moved,
  output logic         spill
);

  localparam int TOP = W - 1;

  logic keep_sign;
  assign keep_sign = (mode == MODE_SIGNED);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic from_left;
    logic from_right;

    if (i == 0) begin : g_low
      assign from_left  = 1'b0;
      assign from_right = src[i+1];
    end else if (i == TOP) begin : g_top
      assign from_left  = keep_sign ? src[TOP] : src[TOP-1];
      assign from_right = keep_sign ? src[TOP] : 1'b0;
    end else begin : g_mid
      assign from_left  = src[i-1];
      assign from_right = src[i+1];
    end

    assign moved[i] = (dir == DIR_LEFT) ? from_left : from_right;
  end

  always_comb begin
    if (dir == DIR_RIGHT) begin
      spill = src[0];
    end else if (keep_sign) begin
      spill = src[TOP-1];
    end else begin
      spill = src[TOP];
    end
  end

endmodule

// File: rtl/sps_outreg.sv
module sps_outreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_word,
  input  logic         d_bit,
  output logic [W-1:0] q_word,
  output logic         q_bit
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_word <= '0;
      q_bit  <= 1'b0;
    end else begin
      q_word <= d_word;
      q_bit  <= d_bit;
    end
  end

endmodule

// File: rtl/sps_shifter.sv
module sps_shifter
  import sps_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] in_word,
  input  logic         in_dir,
  input  logic         in_mode,
  output logic [W-1:0] res_word,
  output logic         res_spill
);

  sps_dir_e     dir_q;
  sps_mode_e    mode_q;
  logic [W-1:0] next_word;
  logic         next_spill;

  assign dir_q  = sps_dir_e'(in_dir);
  assign mode_q = sps_mode_e'(in_mode);

  sps_core #(.W(W)) u_core (
    .src   (in_word),
    .dir   (dir_q),
    .mode  (mode_q),
    .moved (next_word),
    .spill (next_spill)
  );

  sps_outreg #(.W(W)) u_oreg (
    .clk    (clk),
    .rst    (rst),
    .d_word (next_word),
    .d_bit  (next_spill),
    .q_word (res_word),
    .q_bit  (res_spill)
  );

endmodule

// File: rtl/sps_shifter_checker.sv
module sps_shifter_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] in_word,
  input logic         in_dir,
  input logic         in_mode,
  input logic [W-1:0] res_word,
  input logic         res_spill
);

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (res_word == '0 && res_spill == 1'b0));

  // R2, R3
  a_r3_plain_left: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(in_dir) && !$past(in_mode)) |->
      (res_word == {$past(in_word[W-2:0]), 1'b0} && res_spill == $past(in_word[W-1])));

  // R4
  a_r4_plain_right: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(in_dir) && !$past(in_mode)) |->
      (res_word == {1'b0, $past(in_word[W-1:1])} && res_spill == $past(in_word[0])));

  // R5
  a_r5_signed_left: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(in_dir) && $past(in_mode)) |->
      (res_word[W-2:0] == {$past(in_word[W-3:0]), 1'b0} && res_spill == $past(in_word[W-2])));

  // R6
  a_r6_signed_right: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(in_dir) && $past(in_mode)) |->
      (res_word[W-2:0] == $past(in_word[W-1:1]) && res_spill == $past(in_word[0])));

  // R7
  a_r7_sign_fixed: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(in_mode)) |-> (res_word[W-1] == $past(in_word[W-1])));

  // R8
  a_r8_left_zero_fill: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(in_dir)) |-> (res_word[0] == 1'b0));

  a_r8_right_zero_fill: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(in_dir) && !$past(in_mode)) |-> (res_word[W-1] == 1'b0));

endmodule

bind sps_shifter sps_shifter_checker #(.W(W)) u_sps_chk (
  .clk       (clk),
  .rst       (rst),
  .in_word   (in_word),
  .in_dir    (in_dir),
  .in_mode   (in_mode),
  .res_word  (res_word),
  .res_spill (res_spill)
);

// File: tb/sps_shifter_bench.sv
module sps_shifter_bench;

  localparam int W = 8;
  localparam int NVEC = 12;

  // {word, dir, mode, expected word, expected spill}
  localparam logic [18:0] VEC [NVEC] = '{
    {8'b01010011, 1'b0, 1'b0, 8'b10100110, 1'b0},  // R3
    {8'b10110010, 1'b1, 1'b0, 8'b01011001, 1'b0},  // R4
    {8'b01010011, 1'b0, 1'b1, 8'b00100110, 1'b1},  // R5
    {8'b10110010, 1'b1, 1'b1, 8'b11011001, 1'b0},  // R6
    {8'b11111111, 1'b0, 1'b0, 8'b11111110, 1'b1},  // R3
    {8'b11111111, 1'b0, 1'b1, 8'b11111110, 1'b1},  // R5
    {8'b10000000, 1'b0, 1'b1, 8'b10000000, 1'b0},  // R7
    {8'b01000000, 1'b0, 1'b1, 8'b00000000, 1'b1},  // R5
    {8'b10000001, 1'b1, 1'b1, 8'b11000000, 1'b1},  // R6
    {8'b00000001, 1'b1, 1'b0, 8'b00000000, 1'b1},  // R4
    {8'b01111111, 1'b1, 1'b1, 8'b00111111, 1'b1},  // R6
    {8'b10000000, 1'b0, 1'b0, 8'b00000000, 1'b1}   // R3
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] in_word = '0;
  logic         in_dir = 1'b0;
  logic         in_mode = 1'b0;
  logic [W-1:0] res_word;
  logic         res_spill;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  sps_shifter #(.W(W)) u_sps_shifter (
    .clk       (clk),
    .rst       (rst),
    .in_word   (in_word),
    .in_dir    (in_dir),
    .in_mode   (in_mode),
    .res_word  (res_word),
    .res_spill (res_spill)
  );

  task automatic check(input string req, input logic [W-1:0] exp_w, input logic exp_s);
    n_chk++;
    if (res_word !== exp_w || res_spill !== exp_s) begin
      n_bad++;
      $display("FAIL %s: got word=%b spill=%b, expected word=%b spill=%b",
               req, res_word, res_spill, exp_w, exp_s);
    end
  endtask

  function automatic logic [W:0] model(input logic [W-1:0] d, input logic dr, input logic md);
    logic [W-1:0] r;
    logic         s;
    if (!dr) begin
      r = W'((int'(d) * 2) % 256);
      if (md) begin
        r[W-1] = d[W-1];
        s = d[W-2];
      end else begin
        s = d[W-1];
      end
    end else begin
      if (md) r = W'($signed(d) >>> 1);
      else    r = W'(int'(d) / 2);
      s = d[0];
    end
    return {r, s};
  endfunction

  // Drive at posedge+1, capture on the next edge, sample 1 ns after it.
  task automatic apply(input logic [W-1:0] d, input logic dr, input logic md);
    in_word = d;
    in_dir  = dr;
    in_mode = md;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(4 * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [W:0] m;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset state", '0, 1'b0);
    rst = 1'b0;

    for (int k = 0; k < NVEC; k++) begin
      apply(VEC[k][18:11], VEC[k][10], VEC[k][9]);
      check("R3/R4/R5/R6/R7 table", VEC[k][8:1], VEC[k][0]);
    end

    // R2: new inputs must not show before the next edge
    apply(8'b00000011, 1'b0, 1'b0);
    in_word = 8'b11000000;
    in_dir  = 1'b1;
    #1;
    check("R2 hold between edges", 8'b00000110, 1'b0);
    @(posedge clk);
    #1;
    check("R2 update after edge", 8'b01100000, 1'b0);

    // Exhaustive sweep against the model (R3..R8)
    for (int md = 0; md < 2; md++) begin
      for (int dr = 0; dr < 2; dr++) begin
        for (int v = 0; v < 256; v++) begin
          apply(W'(v), 1'(dr), 1'(md));
          m = model(W'(v), 1'(dr), 1'(md));
          check("R3/R4/R5/R6 sweep", m[W:1], m[0]);
          if (md == 1 && res_word[W-1] !== 1'(v >> 7)) begin
            n_chk++; n_bad++;
            $display("FAIL R7: got sign=%b, expected %b", res_word[W-1], 1'(v >> 7));
          end
          if ((dr == 0 && res_word[0] !== 1'b0) ||
              (dr == 1 && md == 0 && res_word[W-1] !== 1'b0)) begin
            n_chk++; n_bad++;
            $display("FAIL R8: got word=%b, expected zero fill", res_word);
          end
        end
      end
    end

    // R1: reset with data present
    apply(8'b11111111, 1'b0, 1'b0);
    check("R3 before reset", 8'b11111110, 1'b1);
    rst = 1'b1;
    apply(8'b11111111, 1'b1, 1'b1);
    check("R1 reset with data", '0, 1'b0);
    rst = 1'b0;
    apply(8'b10000000, 1'b1, 1'b1);
    check("R6 after reset", 8'b11000000, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule